// File: doc/BRIEF.md
# Fractional UART baud generator

The block produces the single-cycle enable that paces a UART's 16x oversampling logic. The tick period is set by a 13-bit integer divisor and refined by a 5-bit fraction counted in 1/32 steps. The resulting bit rate is module clock / (16 × (divisor + fraction/32)). A fractional accumulator adds the fraction once per period. Each time the accumulator carries out of 5 bits, one extra clock cycle goes into the next period. The longer periods are therefore spread evenly instead of bunched together.

Software sets the block through three byte registers. The high divisor register at address 0x0 holds two independent interrupt-enable flags in bits 7:6 and the upper divisor field in bits 4:0. The low divisor register at address 0x1 holds divisor bits 7:0. The control register at address 0xA holds the fraction in bits 4:0. The expected order is fraction, then high byte, then low byte, with the serial logic held idle meanwhile. The fraction and high byte are only staged. The write to the low byte commits divisor and fraction together and restarts the period from a clean phase. A divisor of zero halts the tick.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset, all three registers read 0x00 and `tick` stays low.
- R2: With fraction 0 and committed divisor D ≥ 1, `tick` is a one-cycle pulse repeating every D clock cycles (every cycle when D = 1).
- R3: With fraction F, the k-th period after the first tick following a commit lasts D + floor(k·F/32) − floor((k−1)·F/32) cycles, so every 32 consecutive periods contain exactly F periods of D+1 cycles.
- R4: A write to the high divisor register (address 0x0, bits 4:0 = divisor bits 12:8) does not alter the running tick period until the low divisor register is written.
- R5: A write to the low divisor register (address 0x1, data = divisor bits 7:0) makes the staged upper bits, the written lower bits and the staged fraction take effect together in the same cycle, and restarts the period and the accumulator.
- R6: A committed divisor of zero keeps `tick` low for as long as it stays committed.
- R7: Bits 7:6 of the high divisor register are stored and read back unchanged by low-byte or control writes; bit 5 reads as 0.
- R8: Reading address 0x1 returns the committed divisor bits 7:0; reading address 0xA returns the staged fraction in bits 4:0 with bits 7:5 as 0; reading 0x0 returns the flags and the staged upper divisor field.
- R9: A write to the control register (address 0xA) does not alter the running tick period until the low divisor register is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regAddr | input | 4 | Register address (0x0 high, 0x1 low, 0xA control) |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for the addressed register, combinational |
| tick | output | 1 | One-cycle oversampling enable |

## Verification
The bench builds the block with its default widths: a 13-bit divisor, a 5-bit fraction and a 4-bit address. This brings divisor 1 (a tick every cycle), small divisors with fractions 1, 13 and 31, and a divisor above 255 within reach. The last one exercises the staged upper field in a genuine commit. Fraction and high-byte writes are placed in the middle of a running tick stream, so the staging is checked against the live period rather than only by read-back.

// File: rtl/baud_pkg.sv
package baud_pkg;
  // Strobes from the register side to the counting datapath
  typedef struct packed {
    logic commit;  // new divisor and fraction take effect this edge
    logic run;     // committed divisor is non-zero
  } baudStrobe_t;
endpackage

// File: rtl/baud_regs.sv
module baud_regs
  import baud_pkg::*;
#(
  parameter int DIV_W     = 13,
  parameter int FRAC_W    = 5,
  parameter int ADDR_W    = 4,
  parameter int HI_ADDR   = 0,
  parameter int LO_ADDR   = 1,
  parameter int CTRL_ADDR = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  output logic [DIV_W-1:0]  divAct,
  output logic [FRAC_W-1:0] fracAct,
  output baudStrobe_t       strb
);
  localparam int HI_W   = DIV_W - 8;
  localparam int HI_PAD = 6 - HI_W;
  localparam int FR_PAD = 8 - FRAC_W;

  logic [1:0]        ieBits;
  logic [HI_W-1:0]   hiStage;
  logic [FRAC_W-1:0] fracStage;
  logic wrHi, wrLo, wrCtrl;

  assign wrHi   = regWrEn && (regAddr == ADDR_W'(HI_ADDR));
  assign wrLo   = regWrEn && (regAddr == ADDR_W'(LO_ADDR));
  assign wrCtrl = regWrEn && (regAddr == ADDR_W'(CTRL_ADDR));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ieBits    <= '0;
      hiStage   <= '0;
      fracStage <= '0;
      divAct    <= '0;
      fracAct   <= '0;
    end else begin
      if (wrHi) begin
        ieBits  <= regWrData[7:6];
        hiStage <= regWrData[HI_W-1:0];
      end
      if (wrCtrl) fracStage <= regWrData[FRAC_W-1:0];
      if (wrLo) begin
        divAct  <= {hiStage, regWrData};
        fracAct <= fracStage;
      end
    end
  end

  assign strb.commit = wrLo;
  assign strb.run    = (divAct != '0);

  always_comb begin
    regRdData = 8'h00;
    if (regAddr == ADDR_W'(HI_ADDR))
      regRdData = {ieBits, {HI_PAD{1'b0}}, hiStage};
    else if (regAddr == ADDR_W'(LO_ADDR))
      regRdData = divAct[7:0];
    else if (regAddr == ADDR_W'(CTRL_ADDR))
      regRdData = {{FR_PAD{1'b0}}, fracStage};
  end

  AST_IE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr != ADDR_W'(HI_ADDR)) |=> $stable(ieBits)); // R7
  AST_HI_BUFFERED: assert property (@(posedge clk) disable iff (!rstN)
    wrHi |=> ($stable(divAct) && $stable(fracAct))); // R4
  AST_FRAC_BUFFERED: assert property (@(posedge clk) disable iff (!rstN)
    wrCtrl |=> ($stable(fracAct) && $stable(divAct))); // R9
endmodule

// File: rtl/baud_dp.sv
module baud_dp
  import baud_pkg::*;
#(
  parameter int DIV_W  = 13,
  parameter int FRAC_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  divAct,
  input  logic [FRAC_W-1:0] fracAct,
  input  baudStrobe_t       strb,
  output logic              tick
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  target;
  logic [FRAC_W-1:0] acc;
  logic              extraNow;
  logic [FRAC_W:0]   sum;
  logic              hit;

  // Period length is the divisor plus one stretch cycle when the
  // accumulator carried at the end of the previous period.
  assign target = {1'b0, divAct} + CNT_W'(extraNow);
  assign hit    = strb.run && (cnt == target);
  assign sum    = {1'b0, acc} + {1'b0, fracAct};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= CNT_W'(1);
      acc      <= '0;
      extraNow <= 1'b0;
    end else if (strb.commit) begin
      cnt      <= CNT_W'(1);
      acc      <= '0;
      extraNow <= 1'b0;
    end else if (hit) begin
      cnt      <= CNT_W'(1);
      acc      <= sum[FRAC_W-1:0];
      extraNow <= sum[FRAC_W];
    end else if (strb.run) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign tick = hit;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    strb.run |-> (cnt <= target)); // R3
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (tick && divAct > DIV_W'(1) && !strb.commit) |=> !tick); // R2
  AST_ZERO_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run && !strb.commit) |=> !tick); // R6
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import baud_pkg::*;
#(
  parameter int DIV_W  = 13,
  parameter int FRAC_W = 5,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  output logic              tick
);
  logic [DIV_W-1:0]  divAct;
  logic [FRAC_W-1:0] fracAct;
  baudStrobe_t       strb;

  baud_regs #(.DIV_W(DIV_W), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W)) uRegs (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .divAct(divAct), .fracAct(fracAct), .strb(strb)
  );

  baud_dp #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) uDp (
    .clk(clk), .rstN(rstN), .divAct(divAct), .fracAct(fracAct),
    .strb(strb), .tick(tick)
  );
endmodule

// File: tb/sim_frac_baud_gen.sv
module sim_frac_baud_gen;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [3:0] regAddr = 4'h0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       tick;

  int q[$];
  int nChecks = 0;
  int nFails  = 0;
  bit armed = 0;
  bit skipFirst = 0;
  int gap = 0;
  int tickCount = 0;

  always #2 clk = ~clk;

  frac_baud_gen u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .tick(tick)
  );

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: measure gaps between ticks and compare with the queue
  always @(negedge clk) begin
    gap = gap + 1;
    if (tick) begin
      tickCount++;
      if (armed) begin
        if (skipFirst) skipFirst = 0;
        else if (q.size() == 0) check("R2/R3 unexpected tick", gap, 0);
        else check("R2/R3 period", gap, q.pop_front());
      end
      gap = 0;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdCheck(string req, input logic [3:0] a, input int exp);
    @(negedge clk);
    regAddr = a;
    #1 check(req, int'(regRdData), exp);
  endtask

  task automatic pushPeriods(int d, int f, int n);
    for (int k = 1; k <= n; k++)
      q.push_back(d + (k * f) / 32 - ((k - 1) * f) / 32);
  endtask

  // Low-byte write that arms the scoreboard for the new setting (R5)
  task automatic commit(input logic [7:0] lo, int d, int f, int n);
    armed = 0;
    q.delete();
    pushPeriods(d, f, n);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 4'h1; regWrData = lo;
    #1 begin skipFirst = 1; armed = 1; end
    @(negedge clk);
    regWrEn = 1'b0;
    wait (q.size() == 0);
    armed = 0;
    check("R5 queue drained", q.size(), 0);
  endtask

  task automatic runCfg(int d, int f, int n);
    wr(4'hA, 8'(f));
    wr(4'h0, 8'(d >> 8));
    commit(8'(d & 255), d, f, n);
  endtask

  initial begin
    #(4 * 200000);
    check("watchdog", 1, 0);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    int tc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rdCheck("R1 hi", 4'h0, 0);
    rdCheck("R1 lo", 4'h1, 0);
    rdCheck("R1 ctrl", 4'hA, 0);
    repeat (50) @(negedge clk);
    check("R1 no tick", tickCount, 0);

    // R2 integer divisors
    runCfg(4, 0, 20);
    runCfg(1, 0, 10);
    // R3 fractional spreading
    runCfg(5, 13, 64);
    runCfg(3, 31, 40);
    runCfg(7, 1, 33);
    runCfg(300, 7, 33);

    // R4 / R9: staged writes mid-stream keep the old period
    wr(4'hA, 8'd0);
    wr(4'h0, 8'h00);
    armed = 0; q.delete(); pushPeriods(6, 0, 40);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 4'h1; regWrData = 8'd6;
    #1 begin skipFirst = 1; armed = 1; end
    @(negedge clk);
    regWrEn = 1'b0;
    wait (q.size() < 30);
    wr(4'hA, 8'd9);   // R9 staged fraction
    wr(4'h0, 8'h01);  // R4 staged upper field
    wait (q.size() == 0);
    armed = 0;
    check("R4 R9 stream held", q.size(), 0);
    rdCheck("R8 hi staged", 4'h0, 8'h01);
    rdCheck("R8 ctrl staged", 4'hA, 9);
    rdCheck("R8 lo still old", 4'h1, 6);
    // R5: commit applies 0x102 with fraction 9
    commit(8'h02, 258, 9, 12);
    rdCheck("R5 lo committed", 4'h1, 2);

    // R6 divisor zero stops tick
    wr(4'h0, 8'h00);
    wr(4'h1, 8'h00);
    repeat (5) @(negedge clk);
    tc = tickCount;
    repeat (300) @(negedge clk);
    check("R6 no tick at zero", tickCount, tc);
    runCfg(2, 0, 10);

    // R7 / R8 flags and read-back
    wr(4'h0, 8'hC3);
    rdCheck("R7 hi flags", 4'h0, 8'hC3);
    wr(4'h1, 8'h10);
    wr(4'hA, 8'hFF);
    rdCheck("R7 flags kept", 4'h0, 8'hC3);
    rdCheck("R8 ctrl masked", 4'hA, 8'h1F);
    rdCheck("R8 lo", 4'h1, 8'h10);
    wr(4'h0, 8'h20);
    rdCheck("R7 bit5 zero", 4'h0, 8'h00);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule